// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations for a 14-bit virtual address space and a 12-bit physical address space with 64-byte pages. A lookup presents a full virtual address. In the same cycle the block reports whether a valid translation exists. On a hit it also returns the physical address, built from the stored physical page number and the untouched page offset.

When a lookup misses, logic outside the block resolves the translation, for example by a page-table walk. That logic then installs the result through the fill port. The 16 entries are arranged as 4 sets of 4 ways. On a fill, a way that already holds the same page is updated first. Failing that, the lowest-numbered empty way is used. When the set is full, a per-set rotating victim pointer chooses the way.

A flush input empties the whole buffer in one clock, for use on a context switch. The block has no state machine. Fill handling is a three-way choice, recorded per fill as one of the kinds `FILL_UPDATE`, `FILL_FREE` or `FILL_EVICT`, plus `FILL_NONE` when no fill is requested.

Top module: `tlb_sa`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses and `lk_paddr` reads 0.
- R2: The virtual page number is `lk_vaddr[13:6]` and the offset is `lk_vaddr[5:0]`. The set is selected by VPN bits [1:0] and the tag is VPN bits [7:2]. Pages with equal tags in different sets, and pages with different tags in one set, are held independently.
- R3: `lk_hit` is 1 only when a valid way of the selected set holds a matching tag. On a hit, `lk_paddr` = {stored PPN, `lk_vaddr[5:0]`}. On a miss, `lk_paddr` is 0. Both outputs are combinational from `lk_vaddr`.
- R4: Suppose VPN 0x0F has been filled with PPN 0x0D. A lookup of virtual address 0x03D4 (set 3, tag 0x03) then hits with physical address 0x354.
- R5: A fill is registered at the rising clock edge. Before that edge, lookups of the new page still miss. From that edge on, they hit.
- R6: A fill of a page not present in its set goes to the lowest-numbered invalid way. Up to 4 distinct pages per set therefore coexist with no eviction.
- R7: A fill of a new page into a full set replaces the way named by that set's victim pointer, then advances the pointer by one, wrapping after way 3. The pointer starts at way 0 after reset or flush.
- R8: Filling a page already present in its set rewrites that way's PPN. No other entry is disturbed and the victim pointer does not move.
- R9: `flush` clears every valid bit at the next clock edge. A fill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 14 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_paddr | output | 12 | Translated physical address, 0 on miss |
| fl_en | input | 1 | Install a translation at the next edge |
| fl_vpn | input | 8 | Virtual page number to install |
| fl_ppn | input | 6 | Physical page number to install |
| flush | input | 1 | Invalidate all entries at the next edge |

## Verification
The bench fills a single set past its capacity several times and checks which page disappears at each step. A design with a wrong or stuck victim pointer would evict a page that should still hit. It also refills a page already present in a full set. A design that does not detect the existing page would either hold two copies or evict an unrelated neighbour. The bench samples lookups on both sides of the fill edge, and it asserts flush and fill together. Lookups sampled too early would return stale results, and an incorrect flush priority would leave an entry alive after the flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 14;
    localparam int PA_W  = 12;
    localparam int OFF_W = 6;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_UPDATE = 2'd1,
        FILL_FREE   = 2'd2,
        FILL_EVICT  = 2'd3
    } fill_kind_e;
endpackage

// File: rtl/tlb_way_pick.sv
module tlb_way_pick
    import tlb_pkg::*;
(
    input  logic             req,
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  match,
    input  logic [WAY_W-1:0] victim,
    output fill_kind_e       kind,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] match_way;
    logic [WAY_W-1:0] free_way;
    logic             any_free;

    always_comb begin
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) match_way = WAY_W'(w);
        end
    end

    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        if (!req)         kind = FILL_NONE;
        else if (|match)  kind = FILL_UPDATE;
        else if (any_free) kind = FILL_FREE;
        else              kind = FILL_EVICT;
    end

    always_comb begin
        unique case (kind)
            FILL_UPDATE: way = match_way;
            FILL_FREE:   way = free_way;
            FILL_EVICT:  way = victim;
            default:     way = '0;
        endcase
    end
endmodule

// File: rtl/tlb_set.sv
module tlb_set
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PPN_W-1:0] fill_ppn
);
    logic [WAYS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q [WAYS];
    logic [PPN_W-1:0] ppn_q [WAYS];
    logic [WAY_W-1:0] rr_q;

    logic [WAYS-1:0]  hit_vec;
    logic [WAYS-1:0]  fill_match;
    fill_kind_e       kind;
    logic [WAY_W-1:0] tgt_way;

    always_comb begin
        lk_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w]    = valid_q[w] && (tag_q[w] == lk_tag);
            fill_match[w] = valid_q[w] && (tag_q[w] == fill_tag);
            if (hit_vec[w]) lk_ppn = lk_ppn | ppn_q[w];
        end
    end
    assign lk_hit = |hit_vec;

    tlb_way_pick u_pick (
        .req    (fill_en && !flush),
        .valid  (valid_q),
        .match  (fill_match),
        .victim (rr_q),
        .kind   (kind),
        .way    (tgt_way)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (kind != FILL_NONE) begin
            valid_q[tgt_way] <= 1'b1;
            if (kind == FILL_EVICT) rr_q <= rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                tag_q[w] <= '0;
                ppn_q[w] <= '0;
            end
        end else if (kind != FILL_NONE) begin
            tag_q[tgt_way] <= fill_tag;
            ppn_q[tgt_way] <= fill_ppn;
        end
    end

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R8
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R6
    valid_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ($countones(valid_q) >= $countones($past(valid_q))));

    // R7
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && (&valid_q) && !(|fill_match)) |=> (rr_q == $past(rr_q) + 1'b1));

    // R8
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && (|fill_match)) |=> $stable(rr_q));
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fl_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic             flush
);
    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] fl_idx;
    logic [TAG_W-1:0] fl_tag;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign fl_idx = fl_vpn[IDX_W-1:0];
    assign fl_tag = fl_vpn[VPN_W-1:IDX_W];

    logic [SETS-1:0]  set_hit;
    logic [PPN_W-1:0] set_ppn [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        tlb_set u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .lk_tag   (lk_tag),
            .lk_hit   (set_hit[s]),
            .lk_ppn   (set_ppn[s]),
            .fill_en  (fl_en && (fl_idx == IDX_W'(s))),
            .fill_tag (fl_tag),
            .fill_ppn (fl_ppn)
        );
    end

    assign lk_hit   = set_hit[lk_idx];
    assign lk_paddr = lk_hit ? {set_ppn[lk_idx], lk_off} : '0;

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !lk_hit);
endmodule

// File: tb/tlb_sa_bench.sv
module tlb_sa_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [11:0] lk_paddr;
    logic        fl_en = 1'b0;
    logic [7:0]  fl_vpn = '0;
    logic [5:0]  fl_ppn = '0;
    logic        flush = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tlb_sa u_tlb_sa (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
        .flush(flush)
    );

    function automatic logic [7:0] vpn_of(input logic [5:0] tag, input logic [1:0] set);
        return {tag, set};
    endfunction

    task automatic look(input string req, input logic [7:0] vpn, input logic [5:0] off,
                        input bit exp_hit, input logic [5:0] exp_ppn);
        logic [11:0] exp_pa;
        lk_vaddr = {vpn, off};
        #1;
        exp_pa = exp_hit ? {exp_ppn, off} : 12'h000;
        n_chk++;
        if (lk_hit !== exp_hit || lk_paddr !== exp_pa) begin
            n_bad++;
            $display("FAIL %s vpn=%h: hit=%b pa=%h expected hit=%b pa=%h",
                     req, vpn, lk_hit, lk_paddr, exp_hit, exp_pa);
        end
    endtask

    task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn);
        @(negedge clk);
        fl_en = 1'b1; fl_vpn = vpn; fl_ppn = ppn;
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        look("R1", 8'h0F, 6'h14, 0, 0);
        look("R1", 8'h00, 6'h00, 0, 0);
    endtask

    task automatic t_example();
        fill(8'h0F, 6'h0D);
        lk_vaddr = 14'h03D4;
        #1;
        n_chk++;
        if (lk_hit !== 1'b1 || lk_paddr !== 12'h354) begin
            n_bad++;
            $display("FAIL R4: hit=%b pa=%h expected hit=1 pa=354", lk_hit, lk_paddr);
        end
    endtask

    task automatic t_split();
        do_flush();
        fill(vpn_of(6'h03, 2'd3), 6'h0D);
        fill(vpn_of(6'h03, 2'd0), 6'h21);
        fill(vpn_of(6'h07, 2'd3), 6'h05);
        look("R2", vpn_of(6'h03, 2'd3), 6'h3F, 1, 6'h0D);
        look("R2", vpn_of(6'h03, 2'd0), 6'h01, 1, 6'h21);
        look("R2", vpn_of(6'h07, 2'd3), 6'h2A, 1, 6'h05);
        look("R3", vpn_of(6'h03, 2'd1), 6'h10, 0, 0);
        look("R3", vpn_of(6'h07, 2'd0), 6'h10, 0, 0);
    endtask

    task automatic t_timing();
        do_flush();
        @(negedge clk);
        fl_en = 1'b1; fl_vpn = 8'h55; fl_ppn = 6'h33;
        look("R5 before edge", 8'h55, 6'h07, 0, 0);
        @(posedge clk);
        #1;
        fl_en = 1'b0;
        look("R5 after edge", 8'h55, 6'h07, 1, 6'h33);
    endtask

    task automatic t_free_ways();
        do_flush();
        for (int t = 1; t <= 4; t++) fill(vpn_of(6'(t), 2'd0), 6'(t + 8));
        for (int t = 1; t <= 4; t++) look("R6", vpn_of(6'(t), 2'd0), 6'h00, 1, 6'(t + 8));
    endtask

    task automatic t_round_robin();
        do_flush();
        for (int t = 1; t <= 4; t++) fill(vpn_of(6'(t), 2'd1), 6'(t + 16));
        // each new page evicts the oldest in way order 0,1,2,3,0
        for (int t = 5; t <= 9; t++) begin
            fill(vpn_of(6'(t), 2'd1), 6'(t + 16));
            look("R7 evicted", vpn_of(6'(t - 4), 2'd1), 6'h00, 0, 0);
            for (int k = t - 3; k <= t; k++)
                look("R7 kept", vpn_of(6'(k), 2'd1), 6'h05, 1, 6'(k + 16));
        end
    endtask

    task automatic t_refresh();
        do_flush();
        for (int t = 1; t <= 4; t++) fill(vpn_of(6'(t), 2'd2), 6'(t + 32));
        fill(vpn_of(6'd3, 2'd2), 6'h2A);
        look("R8 updated", vpn_of(6'd3, 2'd2), 6'h11, 1, 6'h2A);
        look("R8 kept", vpn_of(6'd1, 2'd2), 6'h11, 1, 6'd33);
        look("R8 kept", vpn_of(6'd2, 2'd2), 6'h11, 1, 6'd34);
        look("R8 kept", vpn_of(6'd4, 2'd2), 6'h11, 1, 6'd36);
        fill(vpn_of(6'd5, 2'd2), 6'h3C);
        look("R8 pointer held", vpn_of(6'd1, 2'd2), 6'h00, 0, 0);
        look("R8 pointer held", vpn_of(6'd2, 2'd2), 6'h00, 1, 6'd34);
        look("R8 new", vpn_of(6'd5, 2'd2), 6'h00, 1, 6'h3C);
    endtask

    task automatic t_flush();
        fill(8'hAA, 6'h01);
        fill(8'h13, 6'h02);
        do_flush();
        look("R9", 8'hAA, 6'h00, 0, 0);
        look("R9", 8'h13, 6'h00, 0, 0);
        look("R9", vpn_of(6'd2, 2'd2), 6'h00, 0, 0);
        @(negedge clk);
        fl_en = 1'b1; flush = 1'b1; fl_vpn = 8'h77; fl_ppn = 6'h15;
        @(negedge clk);
        fl_en = 1'b0; flush = 1'b0;
        look("R9 flush wins", 8'h77, 6'h00, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_split();
        t_timing();
        t_free_ways();
        t_round_robin();
        t_refresh();
        t_flush();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule